// File: doc/BRIEF.md
# Sampled Utility Monitor with Two-Core Way Partitioner

This block decides how the ways of a 16-way shared cache are divided between two cores. Each core has its own monitor. The monitor keeps a small shadow tag directory for a fixed sample of the cache sets and runs true LRU replacement on it. Every shadow hit increments a counter for the recency position where the line was found. LRU is a stack algorithm, so the sum of the first k position counters gives the hits the core would have had with k ways of its own.

The interval counter advances on each cycle where the tick input is high. When a full interval of ticks has elapsed, a search engine takes a snapshot of both sets of counters. It then tries every split that leaves at least one way to each core, one candidate per cycle, and keeps the split with the largest combined predicted hits. When the search finishes, the engine outputs the number of ways for core 0 together with a one-cycle done pulse. The enforcement logic in the shared cache reads this value. When the snapshot is taken, all live counters are halved, so older behaviour keeps a decaying weight.

Top module: `wp_top`

## Requirements
- R1: While reset is asserted and after it, until the first decision, `alloc0_o` equals WAYS/2 (8 by default) and `done_o` is low.
- R2: An access is shadowed only when the low SAMPLE_SHIFT bits of its set index are all zero (one set in 32 by default). The upper bits select the shadow set. Any other access, or one with valid low, changes no monitor state.
- R3: On a shadow hit at recency position p (0 = most recent), counter Hp of that core increments and the line moves to position 0. On a shadow miss the tag is filled at position 0, the line at position WAYS-1 is dropped, and no counter changes.
- R4: Each decision selects the value a in 1..WAYS-1 that maximises (core 0 H0..H(a-1)) plus (core 1 H0..H(WAYS-1-a)). The counters used are those captured at the start of the search.
- R5: When two candidates score equally, the smaller a is chosen.
- R6: In the cycle where a search starts, every counter of both monitors becomes floor(value/2). A hit in that same cycle is then added to the halved value. The snapshot holds the values from before the halving.
- R7: A counter at its maximum value 2^CNT_W-1 stays there on further hits.
- R8: A search starts at the clock edge where the tick input is high and INTERVAL_TICKS ticks have been counted since the previous interval boundary. Cycles with the tick low do not count. An interval boundary that falls while a search is running is skipped.
- R9: `alloc0_o` and `done_o` take the result WAYS-1 clock edges after the edge at which the search started. `done_o` is high for exactly that one cycle, and `alloc0_o` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_vld | input | 1 | Core 0 access valid |
| c0_set | input | SET_W | Core 0 set index |
| c0_tag | input | TAG_W | Core 0 tag |
| c1_vld | input | 1 | Core 1 access valid |
| c1_set | input | SET_W | Core 1 set index |
| c1_tag | input | TAG_W | Core 1 tag |
| tick_i | input | 1 | Interval tick, counted when high |
| alloc0_o | output | $clog2(WAYS) | Ways given to core 0; core 1 gets the rest |
| done_o | output | 1 | One-cycle pulse when a new allocation is output |

## Verification
The bench holds traffic entirely in unsampled sets, so every score is zero. A design that mis-decodes the sample rule, or that breaks ties toward the larger split, then moves away from one way for core 0. Cyclic reuse of 3, 6 and 12 tags puts hits at known stack depths. A design with a wrong shift or promotion lands those hits at the wrong depth and picks a different split, and a rotation of 20 tags must produce only misses. Long single-tag streams drive counters into saturation, where a design that wraps drops the heavy core's share. An idle phase after heavy use exposes missing or misplaced halving. Sparse ticks and ticks held low move the decision edges, which exposes a wrong interval count or wrong result latency.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic {
        PH_IDLE,
        PH_SCAN
    } phase_e;
endpackage

// File: rtl/wp_umon.sv
module wp_umon #(
    parameter int WAYS         = 16,
    parameter int SET_W        = 10,
    parameter int SAMPLE_SHIFT = 5,
    parameter int TAG_W        = 12,
    parameter int CNT_W        = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc_vld,
    input  logic [SET_W-1:0]                acc_set,
    input  logic [TAG_W-1:0]                acc_tag,
    input  logic                            halve_i,
    output logic [WAYS-2:0][CNT_W-1:0]      hits_o
);
    localparam int SIDX_W = SET_W - SAMPLE_SHIFT;
    localparam int NSETS  = 1 << SIDX_W;
    localparam int POS_W  = $clog2(WAYS);

    typedef struct packed {
        logic [NSETS-1:0][WAYS-1:0]             vld;
        logic [NSETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [WAYS-1:0][CNT_W-1:0]             hit;
    } mon_t;

    mon_t              q, d;
    logic              sampled;
    logic [SIDX_W-1:0] sidx;
    logic              hit_f;
    logic [POS_W-1:0]  hit_p;
    logic [POS_W-1:0]  last_p;
    logic [CNT_W-1:0]  base;

    always_comb begin
        sampled = acc_vld && (acc_set[SAMPLE_SHIFT-1:0] == '0);
        sidx    = acc_set[SET_W-1:SAMPLE_SHIFT];
        hit_f   = 1'b0;
        hit_p   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (q.vld[sidx][i] && (q.tag[sidx][i] == acc_tag)) begin
                hit_f = 1'b1;
                hit_p = POS_W'(i);
            end
        end
        // a miss shifts the whole stack, a hit only the part above it
        last_p = hit_f ? hit_p : POS_W'(WAYS - 1);

        d = q;
        if (sampled) begin
            for (int i = 1; i < WAYS; i++) begin
                if (POS_W'(i) <= last_p) begin
                    d.vld[sidx][i] = q.vld[sidx][i-1];
                    d.tag[sidx][i] = q.tag[sidx][i-1];
                end
            end
            d.vld[sidx][0] = 1'b1;
            d.tag[sidx][0] = acc_tag;
        end

        base = '0;
        for (int i = 0; i < WAYS; i++) begin
            base = halve_i ? (q.hit[i] >> 1) : q.hit[i];
            if (sampled && hit_f && (hit_p == POS_W'(i)) && (base != '1)) begin
                base = base + 1'b1;
            end
            d.hit[i] = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int i = 0; i < WAYS - 1; i++) begin
            hits_o[i] = q.hit[i];
        end
    end
endmodule

// File: rtl/wp_search.sv
module wp_search
    import wp_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int CNT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [WAYS-2:0][CNT_W-1:0]   h0_i,
    input  logic [WAYS-2:0][CNT_W-1:0]   h1_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [$clog2(WAYS)-1:0]      alloc_o
);
    localparam int AW    = $clog2(WAYS);
    localparam int SUM_W = CNT_W + AW;
    localparam int SC_W  = SUM_W + 1;
    localparam int LAST  = WAYS - 1;

    typedef struct packed {
        phase_e                      phase;
        logic [AW-1:0]               cand;
        logic [AW-1:0]               best_a;
        logic [AW-1:0]               alloc;
        logic [WAYS-2:0][CNT_W-1:0]  s0;
        logic [WAYS-2:0][CNT_W-1:0]  s1;
        logic [SUM_W-1:0]            pre0;
        logic [SUM_W-1:0]            suf1;
        logic [SC_W-1:0]             best;
        logic                        done;
    } eng_t;

    eng_t              q, d;
    logic [SUM_W-1:0]  tot1;
    logic [SUM_W-1:0]  pre_n;
    logic [SC_W-1:0]   score;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        tot1   = '0;
        pre_n  = '0;
        score  = '0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    for (int i = 0; i < WAYS - 1; i++) begin
                        tot1 = tot1 + SUM_W'(h1_i[i]);
                    end
                    d.s0     = h0_i;
                    d.s1     = h1_i;
                    d.pre0   = '0;
                    d.suf1   = tot1;
                    d.cand   = AW'(1);
                    d.best   = '0;
                    d.best_a = AW'(1);
                    d.phase  = PH_SCAN;
                end
            end
            PH_SCAN: begin
                pre_n = q.pre0 + SUM_W'(q.s0[q.cand - 1'b1]);
                score = SC_W'(pre_n) + SC_W'(q.suf1);
                // strict compare keeps the earlier (smaller) candidate on ties
                if ((q.cand == AW'(1)) || (score > q.best)) begin
                    d.best   = score;
                    d.best_a = q.cand;
                end
                d.pre0 = pre_n;
                d.suf1 = q.suf1 - SUM_W'(q.s1[AW'(LAST) - q.cand]);
                if (q.cand == AW'(LAST)) begin
                    d.alloc = ((q.cand == AW'(1)) || (score > q.best)) ? q.cand : q.best_a;
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    d.cand = q.cand + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.alloc <= AW'(WAYS / 2);
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.phase == PH_SCAN);
    assign done_o  = q.done;
    assign alloc_o = q.alloc;
endmodule

// File: rtl/wp_top.sv
module wp_top #(
    parameter int WAYS           = 16,
    parameter int SET_W          = 10,
    parameter int SAMPLE_SHIFT   = 5,
    parameter int TAG_W          = 12,
    parameter int CNT_W          = 16,
    parameter int INTERVAL_TICKS = 5000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     c0_vld,
    input  logic [SET_W-1:0]         c0_set,
    input  logic [TAG_W-1:0]         c0_tag,
    input  logic                     c1_vld,
    input  logic [SET_W-1:0]         c1_set,
    input  logic [TAG_W-1:0]         c1_tag,
    input  logic                     tick_i,
    output logic [$clog2(WAYS)-1:0]  alloc0_o,
    output logic                     done_o
);
    localparam int ICNT_W = $clog2(INTERVAL_TICKS);
    localparam int NCORE  = 2;

    typedef struct packed {
        logic [ICNT_W-1:0] icnt;
    } tim_t;

    tim_t                                   q, d;
    logic                                   start_w;
    logic                                   busy_w;
    logic                                   last_tick;
    logic [NCORE-1:0]                       vld_a;
    logic [NCORE-1:0][SET_W-1:0]            set_a;
    logic [NCORE-1:0][TAG_W-1:0]            tag_a;
    logic [NCORE-1:0][WAYS-2:0][CNT_W-1:0]  hits_a;

    assign vld_a = {c1_vld, c0_vld};
    assign set_a = {c1_set, c0_set};
    assign tag_a = {c1_tag, c0_tag};

    always_comb begin
        d         = q;
        last_tick = (q.icnt == ICNT_W'(INTERVAL_TICKS - 1));
        start_w   = tick_i && last_tick && !busy_w;
        if (tick_i) begin
            d.icnt = last_tick ? '0 : q.icnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_mon
        wp_umon #(
            .WAYS         (WAYS),
            .SET_W        (SET_W),
            .SAMPLE_SHIFT (SAMPLE_SHIFT),
            .TAG_W        (TAG_W),
            .CNT_W        (CNT_W)
        ) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_vld (vld_a[c]),
            .acc_set (set_a[c]),
            .acc_tag (tag_a[c]),
            .halve_i (start_w),
            .hits_o  (hits_a[c])
        );
    end

    wp_search #(
        .WAYS  (WAYS),
        .CNT_W (CNT_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .h0_i    (hits_a[0]),
        .h1_i    (hits_a[1]),
        .busy_o  (busy_w),
        .done_o  (done_o),
        .alloc_o (alloc0_o)
    );
endmodule

// File: rtl/wp_top_chk.sv
module wp_top_chk #(
    parameter int WAYS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [$clog2(WAYS)-1:0]  alloc,
    input logic                     done
);
    localparam int AW = $clog2(WAYS);

    AST_RESET_ALLOC: assert property (@(posedge clk)
        !rst_n |=> (alloc == AW'(WAYS / 2)) && !done); // R1

    AST_ALLOC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc >= AW'(1)) && (alloc <= AW'(WAYS - 1))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(alloc)); // R9
endmodule

bind wp_top wp_top_chk #(.WAYS(WAYS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc0_o),
    .done  (done_o)
);

// File: tb/wp_top_test.sv
module wp_top_test;
    localparam int WAYS  = 16;
    localparam int SET_W = 8;
    localparam int SS    = 5;
    localparam int TAG_W = 6;
    localparam int CNT_W = 6;
    localparam int NINT  = 40;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int NSH   = 1 << (SET_W - SS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               c0_vld = 1'b0, c1_vld = 1'b0, tick_i = 1'b0;
    logic [SET_W-1:0]   c0_set = '0, c1_set = '0;
    logic [TAG_W-1:0]   c0_tag = '0, c1_tag = '0;
    logic [3:0]         alloc0_o;
    logic               done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wp_top #(
        .WAYS(WAYS), .SET_W(SET_W), .SAMPLE_SHIFT(SS), .TAG_W(TAG_W),
        .CNT_W(CNT_W), .INTERVAL_TICKS(NINT)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .c0_vld(c0_vld), .c0_set(c0_set), .c0_tag(c0_tag),
        .c1_vld(c1_vld), .c1_set(c1_set), .c1_tag(c1_tag),
        .tick_i(tick_i), .alloc0_o(alloc0_o), .done_o(done_o)
    );

    // behavioural reference model
    int shq[2][NSH][$];
    int hc[2][WAYS];
    int icnt, scan_left, pend_a, exp_alloc;
    bit exp_done;

    function automatic int pick_split();
        int best = -1;
        int ba = 1;
        for (int a = 1; a < WAYS; a++) begin
            int s = 0;
            for (int k = 0; k < a; k++) s += hc[0][k];
            for (int k = 0; k < WAYS - a; k++) s += hc[1][k];
            if (s > best) begin best = s; ba = a; end
        end
        return ba;
    endfunction

    task automatic touch(input int c, input bit v, input int s, input int t);
        int sx, idx;
        if (v && (s % (1 << SS)) == 0) begin
            sx = s >> SS;
            idx = -1;
            for (int k = 0; k < shq[c][sx].size(); k++)
                if (shq[c][sx][k] == t) begin idx = k; break; end
            if (idx >= 0) begin
                if (hc[c][idx] < CMAX) hc[c][idx]++;
                shq[c][sx].delete(idx);
            end
            shq[c][sx].push_front(t);
            if (shq[c][sx].size() > WAYS) void'(shq[c][sx].pop_back());
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < NSH; s++) shq[c][s].delete();
                for (int k = 0; k < WAYS; k++) hc[c][k] = 0;
            end
            icnt = 0; scan_left = 0; pend_a = 1;
            exp_alloc = WAYS / 2; exp_done = 0;
        end else begin
            bit busy, st;
            busy = scan_left > 0;
            exp_done = 0;
            if (scan_left > 0) begin
                scan_left--;
                if (scan_left == 0) begin exp_alloc = pend_a; exp_done = 1; end
            end
            st = tick_i && (icnt == NINT - 1) && !busy;
            if (tick_i) icnt = (icnt == NINT - 1) ? 0 : icnt + 1;
            if (st) begin
                pend_a = pick_split();
                scan_left = WAYS - 1;
                for (int c = 0; c < 2; c++)
                    for (int k = 0; k < WAYS; k++) hc[c][k] = hc[c][k] / 2;
            end
            touch(0, c0_vld, int'(c0_set), int'(c0_tag));
            touch(1, c1_vld, int'(c1_set), int'(c1_tag));
        end
    end

    task automatic check(input string req);
        checks++;
        if (int'(alloc0_o) != exp_alloc || done_o !== exp_done) begin
            fails++;
            $display("FAIL %s: alloc=%0d done=%0b expected alloc=%0d done=%0b",
                     req, alloc0_o, done_o, exp_alloc, exp_done);
        end
    endtask

    task automatic gen(input int mode, input int i, output bit v, output int s, output int t);
        v = 1; s = 0; t = 0;
        case (mode)
            0: v = 0;
            1: begin s = (i % NSH) * 32 + 1 + (i % 30); t = i % 4; end   // unsampled only
            2: begin s = 0;   t = i % 3;  end        // hits at depth 2
            3: begin s = 64;  t = 10 + (i % 12); end // hits at depth 11
            4: begin s = 32;  t = 5; end             // hits at depth 0
            5: begin
                v = 1'($urandom % 2);
                s = ($urandom % 2) ? int'(($urandom % NSH) * 32) : int'($urandom % 256);
                t = int'($urandom % 24);
            end
            6: begin s = 96;  t = i % 20; end        // all misses
            7: begin s = 160; t = i % 6;  end        // hits at depth 5
            default: v = 0;
        endcase
    endtask

    task automatic run(input int n, input int m0, input int m1, input int tk, input string req);
        bit v;
        int s, t;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req);
            gen(m0, i, v, s, t);
            c0_vld = v; c0_set = SET_W'(s); c0_tag = TAG_W'(t);
            gen(m1, i, v, s, t);
            c1_vld = v; c1_set = SET_W'(s); c1_tag = TAG_W'(t);
            tick_i = (tk == 0) ? 1'b1 : (tk == 1) ? (i % 3 == 0) : 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) begin @(negedge clk); check("R1 reset value"); end
        rst_n = 1'b1;
        run(10,  0, 0, 2, "R1 hold after reset");
        run(120, 1, 1, 0, "R2 R5 unsampled traffic gives all-zero tie");
        run(200, 2, 3, 0, "R3 R4 R5 depth 2 vs depth 11");
        run(300, 4, 6, 1, "R8 R3 sparse ticks, miss-only core");
        run(250, 7, 4, 0, "R7 saturation depth 5 vs depth 0");
        run(200, 0, 2, 0, "R6 halving decay of idle core");
        run(400, 5, 5, 0, "R4 R6 R7 R9 mixed traffic");
        run(150, 2, 3, 2, "R8 R9 ticks held low");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin @(negedge clk); check("R1 reset mid-run"); end
        rst_n = 1'b1;
        run(100, 3, 7, 0, "R1 R4 after second reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule